// File: doc/BRIEF.md
# 8-bit ALU with flag generation

This block is the combinational arithmetic and logic stage of a small 8-bit accumulator processor. It takes an operation select, a wide first operand, an 8-bit second operand and the current condition flags. It returns a result, the next value of the four flags (zero, subtract, half-carry, carry) and a mask that marks which flags the operation affects. The register file writes back only the flags whose mask bit is set.

Five operations exist. Add an immediate to the accumulator. Decrement a register. Exclusive-OR with a register. Complement the accumulator. Add a sign-extended 8-bit offset to the 16-bit stack pointer. Every carry comes from one rule: the XOR of both operands with their sum, sampled at bit 4 for half-carry and at bit 8 for carry. Each operation sets, clears, computes or keeps each flag by its own rule.

Top module: `alu8_flag_unit`

## Requirements
- R1: With op_sel = 0 (add immediate), result[7:0] = (opnd_a[7:0] + opnd_b) mod 256. The flag vector {Z,N,H,C} sits on bits 3..0 of flags_out and flags_upd. Z is set when result[7:0] is zero, N = 0, H is the carry into bit 4, C is the carry out of bit 7, and flags_upd = 4'b1111.
- R2: For every 8-bit operation (op_sel 0 to 3), result[15:8] is zero, whatever the upper byte of opnd_a holds.
- R3: With op_sel = 1 (decrement), result[7:0] = opnd_a[7:0] - 1 mod 256. Z is set when the result is zero, N = 1, H = 1 exactly when opnd_a[3:0] is 0, C = flags_in C, and flags_upd = 4'b1110.
- R4: With op_sel = 2 (exclusive-OR), result[7:0] = opnd_a[7:0] ^ opnd_b, N = H = C = 0, Z is set when the result is zero (so equal operands give 0 with Z = 1), and flags_upd = 4'b1111.
- R5: With op_sel = 3 (complement), result[7:0] = ~opnd_a[7:0] and N = H = 1. Z and C equal flags_in even when the result is zero, and flags_upd = 4'b0110.
- R6: With op_sel = 4 (stack-pointer offset), result = opnd_a + sign-extended opnd_b mod 65536. Z = 0 and N = 0. H and C are bits 4 and 8 of opnd_a ^ ext ^ sum, and flags_upd = 4'b1111.
- R7: Every flag whose flags_upd bit is 0 appears on flags_out unchanged from flags_in.
- R8: op_sel values 5, 6 and 7 have no effect: result = 0, flags_out = flags_in, flags_upd = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation select (0 add, 1 decrement, 2 XOR, 3 complement, 4 SP offset) |
| opnd_a | input | 16 | Accumulator or register in bits 7:0, stack pointer for op 4 |
| opnd_b | input | 8 | Immediate, register or signed offset |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 16 | Operation result, upper byte zero for 8-bit operations |
| flags_out | output | 4 | Next flags {Z,N,H,C} |
| flags_upd | output | 4 | Per-flag write enable {Z,N,H,C} |

## Verification
The checker treats the block as pure combinational logic. It evaluates its checks once the inputs have settled, so it assumes that op_sel, the operands and flags_in change together and then stay still. The bench follows that rule: it drives every input in one step on the falling clock edge and samples two nanoseconds later. The checker makes no assumption about operand values, and the stimulus includes all-zero, all-one and sign-boundary offsets as well as the reserved select codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   typedef enum logic [2:0] {
      ALU_ADD_IMM = 3'd0,
      ALU_DEC     = 3'd1,
      ALU_XOR     = 3'd2,
      ALU_CPL     = 3'd3,
      ALU_SP_OFS  = 3'd4
   } alu_op_e;

   localparam int FLAG_W = 4;
   localparam int FZ = 3;
   localparam int FN = 2;
   localparam int FH = 1;
   localparam int FC = 0;

   localparam logic [FLAG_W-1:0] MASK_ALL  = 4'b1111;
   localparam logic [FLAG_W-1:0] MASK_DEC  = 4'b1110;
   localparam logic [FLAG_W-1:0] MASK_CPL  = 4'b0110;
   localparam logic [FLAG_W-1:0] MASK_NONE = 4'b0000;
endpackage

// File: rtl/alu8_carry_probe.sv
module alu8_carry_probe #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic [W:0]   cvec
);
   logic [W:0] full;
   always_comb begin
      full = {1'b0, a} + {1'b0, b};
      sum  = full[W-1:0];
      cvec = {1'b0, a} ^ {1'b0, b} ^ full;
   end
endmodule

// File: rtl/alu8_core8.sv
module alu8_core8
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e             op,
   input  logic [DATA_W-1:0]   a8,
   input  logic [DATA_W-1:0]   b8,
   input  logic [FLAG_W-1:0]   fin,
   output logic                hit,
   output logic [DATA_W-1:0]   r8,
   output logic [FLAG_W-1:0]   fout,
   output logic [FLAG_W-1:0]   fmask
);
   localparam int NIB_W = DATA_W / 2;

   logic [DATA_W-1:0] add_sum;
   logic [DATA_W:0]   add_cv;

   alu8_carry_probe #(.W(DATA_W)) u_add (
      .a(a8), .b(b8), .sum(add_sum), .cvec(add_cv)
   );

   always_comb begin
      hit   = 1'b1;
      r8    = '0;
      fout  = fin;
      fmask = MASK_NONE;
      case (op)
         ALU_ADD_IMM: begin
            r8       = add_sum;
            fout[FN] = 1'b0;
            fout[FH] = add_cv[NIB_W];
            fout[FC] = add_cv[DATA_W];
            fmask    = MASK_ALL;
         end
         ALU_DEC: begin
            r8       = a8 - 1'b1;
            fout[FN] = 1'b1;
            fout[FH] = ~|a8[NIB_W-1:0];
            fmask    = MASK_DEC;
         end
         ALU_XOR: begin
            r8       = a8 ^ b8;
            fout[FN] = 1'b0;
            fout[FH] = 1'b0;
            fout[FC] = 1'b0;
            fmask    = MASK_ALL;
         end
         ALU_CPL: begin
            r8       = ~a8;
            fout[FN] = 1'b1;
            fout[FH] = 1'b1;
            fmask    = MASK_CPL;
         end
         default: hit = 1'b0;
      endcase
      if (hit && fmask[FZ]) fout[FZ] = (r8 == '0);
   end
endmodule

// File: rtl/alu8_wide_ofs.sv
module alu8_wide_ofs
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int WIDE_W = 16,
   parameter bit ENABLE = 1'b1
) (
   input  logic [WIDE_W-1:0] base,
   input  logic [DATA_W-1:0] ofs,
   input  logic [FLAG_W-1:0] fin,
   output logic [WIDE_W-1:0] r16,
   output logic [FLAG_W-1:0] fout,
   output logic [FLAG_W-1:0] fmask
);
   localparam int NIB_W = DATA_W / 2;

   generate
      if (ENABLE) begin : g_on
         logic [WIDE_W-1:0] ext;
         logic [WIDE_W-1:0] sum;
         logic [WIDE_W:0]   cv;

         assign ext = {{(WIDE_W-DATA_W){ofs[DATA_W-1]}}, ofs};

         alu8_carry_probe #(.W(WIDE_W)) u_wadd (
            .a(base), .b(ext), .sum(sum), .cvec(cv)
         );

         always_comb begin
            r16      = sum;
            fout     = fin;
            fout[FZ] = 1'b0;
            fout[FN] = 1'b0;
            fout[FH] = cv[NIB_W];
            fout[FC] = cv[DATA_W];
            fmask    = MASK_ALL;
         end
      end else begin : g_off
         always_comb begin
            r16   = '0;
            fout  = fin;
            fmask = MASK_NONE;
         end
      end
   endgenerate
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
   import alu8_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int WIDE_W     = 16,
   parameter bit HAS_SP_OFS = 1'b1
) (
   input  logic [2:0]        op_sel,
   input  logic [WIDE_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [3:0]        flags_in,
   output logic [WIDE_W-1:0] result,
   output logic [3:0]        flags_out,
   output logic [3:0]        flags_upd
);
   generate
      if (WIDE_W != 2 * DATA_W) begin : g_bad_wide
         $error("WIDE_W must be twice DATA_W");
      end
      if (DATA_W < 4 || DATA_W % 2 != 0) begin : g_bad_data
         $error("DATA_W must be even and at least 4");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   logic                hit8;
   logic [DATA_W-1:0]   r8;
   logic [FLAG_W-1:0]   f8, m8;
   logic [WIDE_W-1:0]   r16;
   logic [FLAG_W-1:0]   f16, m16;

   alu8_core8 #(.DATA_W(DATA_W)) u_core8 (
      .op(op), .a8(opnd_a[DATA_W-1:0]), .b8(opnd_b), .fin(flags_in),
      .hit(hit8), .r8(r8), .fout(f8), .fmask(m8)
   );

   alu8_wide_ofs #(.DATA_W(DATA_W), .WIDE_W(WIDE_W), .ENABLE(HAS_SP_OFS)) u_wide (
      .base(opnd_a), .ofs(opnd_b), .fin(flags_in),
      .r16(r16), .fout(f16), .fmask(m16)
   );

   always_comb begin
      if (hit8) begin
         result    = {{(WIDE_W-DATA_W){1'b0}}, r8};
         flags_out = f8;
         flags_upd = m8;
      end else if (op == ALU_SP_OFS) begin
         result    = r16;
         flags_out = f16;
         flags_upd = m16;
      end else begin
         result    = '0;
         flags_out = flags_in;
         flags_upd = MASK_NONE;
      end
   end
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
   parameter int DATA_W = 8,
   parameter int WIDE_W = 16
) (
   input logic [2:0]        op_sel,
   input logic [WIDE_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [3:0]        flags_in,
   input logic [WIDE_W-1:0] result,
   input logic [3:0]        flags_out,
   input logic [3:0]        flags_upd
);
   always_comb begin
      // R7: masked-off flags pass through
      assert_hold_masked_R7: assert (((flags_out ^ flags_in) & ~flags_upd) == 4'b0000);
      // R2: 8-bit operations leave the upper byte clear
      if (op_sel < 3'd4)
         assert_upper_clear_R2: assert (result[WIDE_W-1:DATA_W] == '0);
      // R1: zero flag matches the 8-bit result on add
      if (op_sel == 3'd0)
         assert_add_zero_R1: assert (flags_out[3] == (result[DATA_W-1:0] == '0) && !flags_out[2]);
      // R3: decrement marks subtract
      if (op_sel == 3'd1)
         assert_dec_sub_R3: assert (flags_out[2] && flags_upd[2] && !flags_upd[0]);
      // R4: XOR clears N, H and C
      if (op_sel == 3'd2)
         assert_xor_clear_R4: assert (flags_out[2:0] == 3'b000);
      // R5: complement flips every low bit
      if (op_sel == 3'd3)
         assert_cpl_flip_R5: assert ((result[DATA_W-1:0] ^ opnd_a[DATA_W-1:0]) == '1);
      // R6: offset add never reports zero or subtract
      if (op_sel == 3'd4)
         assert_ofs_zn_R6: assert (flags_out[3:2] == 2'b00);
      // R8: reserved selects update nothing
      if (op_sel > 3'd4)
         assert_reserved_idle_R8: assert (flags_upd == 4'b0000 && result == '0);
   end
endmodule

bind alu8_flag_unit alu8_checker #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_chk (
   .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
   .result(result), .flags_out(flags_out), .flags_upd(flags_upd)
);

// File: tb/alu8_flag_unit_test.sv
module alu8_flag_unit_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [2:0]  op_sel;
   logic [15:0] opnd_a;
   logic [7:0]  opnd_b;
   logic [3:0]  flags_in;
   logic [15:0] result;
   logic [3:0]  flags_out;
   logic [3:0]  flags_upd;

   int n_chk = 0;
   int n_bad = 0;

   alu8_flag_unit uut (
      .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
      .result(result), .flags_out(flags_out), .flags_upd(flags_upd)
   );

   // {op, a, b, fin, exp_result, exp_flags, exp_mask}
   localparam int NV = 16;
   localparam logic [54:0] VEC [NV] = '{
      {3'd0, 16'h003E, 8'h22, 4'b0000, 16'h0060, 4'b0010, 4'hF},
      {3'd0, 16'h0038, 8'h11, 4'b1111, 16'h0049, 4'b0000, 4'hF},
      {3'd0, 16'h00F0, 8'h10, 4'b0000, 16'h0000, 4'b1001, 4'hF},
      {3'd0, 16'h00FF, 8'h01, 4'b0000, 16'h0000, 4'b1011, 4'hF},
      {3'd0, 16'hAB01, 8'h01, 4'b0000, 16'h0002, 4'b0000, 4'hF},
      {3'd1, 16'h0001, 8'h00, 4'b0001, 16'h0000, 4'b1101, 4'hE},
      {3'd1, 16'h0010, 8'h00, 4'b0000, 16'h000F, 4'b0110, 4'hE},
      {3'd1, 16'hFF00, 8'h00, 4'b0001, 16'h00FF, 4'b0111, 4'hE},
      {3'd2, 16'h005A, 8'hA5, 4'b1111, 16'h00FF, 4'b0000, 4'hF},
      {3'd2, 16'h0077, 8'h77, 4'b0000, 16'h0000, 4'b1000, 4'hF},
      {3'd3, 16'h0035, 8'h00, 4'b1001, 16'h00CA, 4'b1111, 4'h6},
      {3'd3, 16'h00FF, 8'h00, 4'b0000, 16'h0000, 4'b0110, 4'h6},
      {3'd4, 16'hFFFE, 8'h02, 4'b0000, 16'h0000, 4'b0011, 4'hF},
      {3'd4, 16'h1000, 8'hFF, 4'b1111, 16'h0FFF, 4'b0000, 4'hF},
      {3'd4, 16'h00F8, 8'h80, 4'b0000, 16'h0078, 4'b0001, 4'hF},
      {3'd5, 16'h1234, 8'h56, 4'b1010, 16'h0000, 4'b1010, 4'h0}
   };

   function automatic string tag_of(input logic [2:0] op);
      case (op)
         3'd0: return "R1/R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5/R7";
         3'd4: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [2:0] op, input logic [15:0] a,
                        input logic [7:0] b, input logic [3:0] fin);
      @(negedge clk);
      op_sel = op; opnd_a = a; opnd_b = b; flags_in = fin;
      #2;
   endtask

   task automatic check(input string tag, input logic [15:0] er,
                        input logic [3:0] ef, input logic [3:0] em);
      n_chk++;
      if (result !== er || flags_out !== ef || flags_upd !== em) begin
         n_bad++;
         $display("FAIL %s: got res=%h flags=%b mask=%b, expected res=%h flags=%b mask=%b",
                  tag, result, flags_out, flags_upd, er, ef, em);
      end
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      op_sel = 3'd7; opnd_a = 16'h0; opnd_b = 8'h0; flags_in = 4'b0000;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // R8: idle select after reset touches nothing
      apply(3'd7, 16'hFFFF, 8'hFF, 4'b0101);
      check("R8 reset-idle", 16'h0000, 4'b0101, 4'b0000);

      for (int i = 0; i < NV; i++) begin
         logic [54:0] v;
         v = VEC[i];
         apply(v[54:52], v[51:36], v[35:28], v[27:24]);
         check(tag_of(v[54:52]), v[23:8], v[7:4], v[3:0]);
      end

      // R3: sweep all operands, half-borrow when low nibble is zero
      for (int a = 0; a < 256; a++) begin
         logic [7:0] r;
         logic [3:0] ef;
         r  = 8'(a - 1);
         ef = {r == 8'h00, 1'b1, a[3:0] == 4'h0, 1'b0};
         apply(3'd1, 16'(a), 8'h00, 4'b0000);
         check("R3 sweep", {8'h00, r}, ef, 4'hE);
      end

      // R8: remaining reserved codes
      apply(3'd6, 16'h00FF, 8'h01, 4'b1111);
      check("R8 op6", 16'h0000, 4'b1111, 4'b0000);
      apply(3'd7, 16'h8000, 8'h80, 4'b0000);
      check("R8 op7", 16'h0000, 4'b0000, 4'b0000);

      // R6: wrap at top of address space with negative offset
      apply(3'd4, 16'h0000, 8'hFF, 4'b0000);
      check("R6 wrap", 16'hFFFF, 4'b0000, 4'hF);

      // R7: complement keeps Z=1 C=0 from input
      apply(3'd3, 16'h0F00, 8'h00, 4'b1000);
      check("R7 cpl keep", 16'h00FF, 4'b1110, 4'h6);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule